// File: doc/BRIEF.md
# Paged Read Sequencer with CRC16

This block is the read half of the memory-command layer of an add-only memory. The ROM-level layer pulses a select grant. The block then collects a three-byte header: a command byte, the low address byte and the high address byte. After that it offers one byte at a time to the master, which takes each byte with a read request. Three commands are served. The plain data read streams the 2048-byte data area. The status read walks the sparse status space in 8-byte pages. The extended read gives, for each 32-byte data page, the page's redirection byte from status space before the page data. Each command places 16-bit CRCs where its own rules say, so the master can check what it received.

Both memories are internal arrays that leave reset at FFh. They can be changed only through an AND-merging program port, which the write side of the device uses. A bit can therefore only go from 1 to 0. Bit serialisation, ROM commands and write commands live in neighbouring blocks.

The sequencer states are IDLE, CMD, TA1, TA2, REDIR, DATA, CRC_LO, CRC_HI and ONES. The transitions are:
- IDLE to CMD on a select grant.
- CMD to TA1 on a known command byte, or CMD to ONES on any other byte.
- TA1 to TA2 on the low address byte.
- TA2 to REDIR (extended read) or to DATA (other reads) on the high address byte.
- REDIR to CRC_LO when the redirection byte is taken.
- DATA to CRC_LO at the end of a page or at the end of memory.
- CRC_LO to CRC_HI when the low CRC byte is taken.
- CRC_HI to DATA after a redirection CRC or between status pages, to REDIR between extended pages, or to ONES after the final CRC.
- Any state to IDLE on abort.

Top module: `pgread_seq`

## Requirements
- R1: After reset, and in the IDLE, CMD, TA1 and TA2 states, tx_rdy is 0 and tx_dat is FFh. Header bytes (rx_vld) are ignored until sel_grant has been seen in IDLE.
- R2: The header order is command, low address, high address. Only the low 3 bits of the high address byte are kept (start address = {high & 07h, low}). The masked value is what enters the address counter and the CRC.
- R3: Command F0h streams data bytes from the start address through 7FFh. It then sends a CRC16 over the command, both address bytes and every data byte sent, starting from zero. The CRC uses x^16+x^15+x^2+1, is shifted LSB first (reflected constant A001h), and is sent as the bitwise complement of the register, low byte first.
- R4: After the final CRC of any read, and after an unknown command, tx_rdy stays 1 and every byte taken is FFh until abort.
- R5: Command AAh streams status bytes up to the end of the current 8-byte page (address bits [2:0] = 111) and then sends a CRC16. The first page's CRC covers command, address and data.
- R6: Each later status page restarts the CRC from zero and covers only that page's data bytes. The status read ends after the page ending at 7FFh.
- R7: Command A5h first sends the redirection byte of the addressed page, read from status address 100h + (address >> 5). A CRC16 follows that covers command, address and redirection byte.
- R8: After the redirection CRC, the extended read streams data to the end of the 32-byte page, then sends a CRC16 of those data bytes alone. For each later page it sends the redirection byte, a CRC16 of that byte alone, and then the page data.
- R9: Only status addresses 000h–007h, 020h–027h, 040h–047h and 100h–13Fh exist. Other addresses read FFh, and program writes to them are ignored.
- R10: abort returns the block to IDLE from any state in the next cycle. A plain read cut short produces no CRC.
- R11: A command byte other than F0h, AAh or A5h moves to ONES.
- R12: A program write (pg_we, pg_stat selects status space) ANDs pg_dat into the addressed byte, so bits only ever go from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_grant | input | 1 | Pulse from the ROM layer: the device is selected |
| abort | input | 1 | Bus reset event: end the sequence |
| rx_vld | input | 1 | A header byte from the master is present |
| rx_dat | input | 8 | Header byte |
| rd_req | input | 1 | The master takes the offered byte |
| tx_rdy | output | 1 | A byte is on offer |
| tx_dat | output | 8 | Offered byte |
| pg_we | input | 1 | Program write strobe |
| pg_stat | input | 1 | 1 selects status space, 0 selects data space |
| pg_addr | input | 11 | Program address |
| pg_dat | input | 8 | Program data, ANDed into memory |

## Verification
On every cycle, assertions check four things. Abort always empties the offer. ONES holds and returns FFh. An unknown command lands in ONES. The CRC register is zero right after each page CRC is taken. They also check that a status page ends at address bits 111, that a redirection CRC is always followed by page data, and that a plain-read CRC only appears once the end of memory has passed. Only the bench scenarios can show the actual byte streams: CRC values over masked headers, page-by-page CRC coverage, redirection lookup, the sparse status map and AND-merging. The bench compares these against an independent model of memory contents and CRC.

// File: rtl/pgread_pkg.sv
`timescale 1ns/1ps
package pgread_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_TA1, ST_TA2, ST_REDIR,
        ST_DATA, ST_CRC_LO, ST_CRC_HI, ST_ONES
    } seq_st_t;

    typedef enum logic [1:0] {MD_MEM, MD_STAT, MD_EXT, MD_NONE} rd_mode_t;

    localparam logic [7:0] OP_RD_DATA = 8'hF0;
    localparam logic [7:0] OP_RD_STAT = 8'hAA;
    localparam logic [7:0] OP_RD_EXT  = 8'hA5;

    // reflected x^16+x^15+x^2+1, LSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pgread_crc16.sv
`timescale 1ns/1ps
module pgread_crc16
    import pgread_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= 16'h0000;
        else if (clr)  crc <= 16'h0000;
        else if (feed) crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/pgread_datmem.sv
`timescale 1ns/1ps
module pgread_datmem #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdat,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdat
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdat;
        end
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/pgread_statmem.sv
`timescale 1ns/1ps
module pgread_statmem #(
    parameter int AW     = 11,
    parameter int NPAGES = 64,
    localparam int BM     = (NPAGES + 7) / 8,
    localparam int NBYTES = 3 * BM + NPAGES,
    localparam int IW     = $clog2(NBYTES),
    localparam int WIN1   = 32,
    localparam int WIN2   = 64,
    localparam int WINR   = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdat,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdat
);
    logic [7:0] mem [NBYTES];

    function automatic logic [IW:0] locate(input logic [AW-1:0] a);
        int v;
        v = int'(a);
        if (v < BM)                           return {1'b1, IW'(v)};
        else if (v >= WIN1 && v < WIN1 + BM)  return {1'b1, IW'(v - WIN1 + BM)};
        else if (v >= WIN2 && v < WIN2 + BM)  return {1'b1, IW'(v - WIN2 + 2 * BM)};
        else if (v >= WINR && v < WINR + NPAGES) return {1'b1, IW'(v - WINR + 3 * BM)};
        return '0;
    endfunction

    logic [IW:0] wloc, rloc;
    assign wloc = locate(waddr);
    assign rloc = locate(raddr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
        end else if (we && wloc[IW]) begin
            mem[wloc[IW-1:0]] <= mem[wloc[IW-1:0]] & wdat;
        end
    end

    assign rdat = rloc[IW] ? mem[rloc[IW-1:0]] : 8'hFF;
endmodule

// File: rtl/pgread_seq.sv
`timescale 1ns/1ps
module pgread_seq
    import pgread_pkg::*;
#(
    parameter int DATA_BYTES = 2048,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_PAGE  = 8,
    localparam int AW        = $clog2(DATA_BYTES),
    localparam int PW        = $clog2(PAGE_BYTES),
    localparam int SPW       = $clog2(STAT_PAGE),
    localparam int NPAGES    = DATA_BYTES / PAGE_BYTES,
    localparam int REDIR_BASE = 256,
    localparam logic [7:0] HI_MASK = 8'((1 << (AW - 8)) - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_grant,
    input  logic          abort,
    input  logic          rx_vld,
    input  logic [7:0]    rx_dat,
    input  logic          rd_req,
    output logic          tx_rdy,
    output logic [7:0]    tx_dat,
    input  logic          pg_we,
    input  logic          pg_stat,
    input  logic [AW-1:0] pg_addr,
    input  logic [7:0]    pg_dat
);
    seq_st_t       st, st_nx;
    rd_mode_t      mode;
    logic [AW-1:0] addr;
    logic [7:0]    ta_lo;
    logic          redir_ph, wrap;
    logic          take, got, last_here;
    logic          crc_clr, crc_feed;
    logic [7:0]    crc_din;
    logic [15:0]   crc_q;
    logic [AW-1:0] s_raddr;
    logic [7:0]    d_rdat, s_rdat;

    pgread_datmem #(.DEPTH(DATA_BYTES)) u_dmem (
        .clk(clk), .rst_n(rst_n), .we(pg_we && !pg_stat), .waddr(pg_addr),
        .wdat(pg_dat), .raddr(addr), .rdat(d_rdat)
    );

    assign s_raddr = (st == ST_REDIR)
                   ? AW'(REDIR_BASE) + {{PW{1'b0}}, addr[AW-1:PW]}
                   : addr;

    pgread_statmem #(.AW(AW), .NPAGES(NPAGES)) u_smem (
        .clk(clk), .rst_n(rst_n), .we(pg_we && pg_stat), .waddr(pg_addr),
        .wdat(pg_dat), .raddr(s_raddr), .rdat(s_rdat)
    );

    pgread_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .feed(crc_feed),
        .din(crc_din), .crc(crc_q)
    );

    // ---------------- outputs ----------------
    always_comb begin
        tx_rdy = 1'b1;
        tx_dat = 8'hFF;
        unique case (st)
            ST_IDLE, ST_CMD, ST_TA1, ST_TA2: tx_rdy = 1'b0;
            ST_REDIR:  tx_dat = s_rdat;
            ST_DATA:   tx_dat = (mode == MD_STAT) ? s_rdat : d_rdat;
            ST_CRC_LO: tx_dat = ~crc_q[7:0];
            ST_CRC_HI: tx_dat = ~crc_q[15:8];
            ST_ONES:   tx_dat = 8'hFF;
            default:   tx_rdy = 1'b0;
        endcase
    end

    assign take = rd_req && tx_rdy;
    assign got  = rx_vld && (st == ST_CMD || st == ST_TA1 || st == ST_TA2);

    always_comb begin
        unique case (mode)
            MD_MEM:  last_here = (addr == '1);
            MD_STAT: last_here = &addr[SPW-1:0];
            MD_EXT:  last_here = &addr[PW-1:0];
            default: last_here = 1'b1;
        endcase
    end

    // ---------------- CRC control ----------------
    assign crc_clr  = (st == ST_IDLE && sel_grant) || (st == ST_CRC_HI && take);
    assign crc_feed = got || (take && (st == ST_REDIR || st == ST_DATA));
    assign crc_din  = (st == ST_TA2) ? (rx_dat & HI_MASK) : (got ? rx_dat : tx_dat);

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (sel_grant) st_nx = ST_CMD;
            ST_CMD: if (got) begin
                if (rx_dat == OP_RD_DATA || rx_dat == OP_RD_STAT || rx_dat == OP_RD_EXT)
                    st_nx = ST_TA1;
                else
                    st_nx = ST_ONES;
            end
            ST_TA1: if (got) st_nx = ST_TA2;
            ST_TA2: if (got) st_nx = (mode == MD_EXT) ? ST_REDIR : ST_DATA;
            ST_REDIR: if (take) st_nx = ST_CRC_LO;
            ST_DATA: if (take && last_here) st_nx = ST_CRC_LO;
            ST_CRC_LO: if (take) st_nx = ST_CRC_HI;
            ST_CRC_HI: if (take) begin
                if (redir_ph)                      st_nx = ST_DATA;
                else if (wrap || mode == MD_MEM)   st_nx = ST_ONES;
                else if (mode == MD_STAT)          st_nx = ST_DATA;
                else                               st_nx = ST_REDIR;
            end
            ST_ONES: st_nx = ST_ONES;
            default: st_nx = ST_IDLE;
        endcase
        if (abort) st_nx = ST_IDLE;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MD_NONE;
            addr     <= '0;
            ta_lo    <= '0;
            redir_ph <= 1'b0;
            wrap     <= 1'b0;
        end else if (abort) begin
            redir_ph <= 1'b0;
            wrap     <= 1'b0;
        end else begin
            if (st == ST_CMD && got) begin
                case (rx_dat)
                    OP_RD_DATA: mode <= MD_MEM;
                    OP_RD_STAT: mode <= MD_STAT;
                    OP_RD_EXT:  mode <= MD_EXT;
                    default:    mode <= MD_NONE;
                endcase
            end
            if (st == ST_TA1 && got) ta_lo <= rx_dat;
            if (st == ST_TA2 && got) begin
                addr     <= AW'({rx_dat & HI_MASK, ta_lo});
                wrap     <= 1'b0;
                redir_ph <= 1'b0;
            end
            if (st == ST_DATA && take) begin
                addr <= addr + 1'b1;
                wrap <= (addr == '1);
            end
            if (st == ST_REDIR && take)  redir_ph <= 1'b1;
            if (st == ST_CRC_HI && take) redir_ph <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!tx_rdy && tx_dat == 8'hFF));

    // R4
    ones_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ONES && !abort) |=> (st == ST_ONES && tx_rdy && tx_dat == 8'hFF));

    // R6
    crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRC_HI && take && !abort) |=> (crc_q == 16'h0000));

    // R8
    redir_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRC_HI && take && redir_ph && !abort) |=> (st == ST_DATA));

    // R5
    stat_page_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && take && mode == MD_STAT && (&addr[SPW-1:0]) && !abort)
        |=> (st == ST_CRC_LO));

    // R3
    mem_crc_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRC_LO && mode == MD_MEM) |-> wrap);

    // R11
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD && rx_vld && !abort && rx_dat != OP_RD_DATA
         && rx_dat != OP_RD_STAT && rx_dat != OP_RD_EXT) |=> (st == ST_ONES));
endmodule

// File: tb/sim_pgread_seq.sv
`timescale 1ns/1ps
module sim_pgread_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_grant = 1'b0, abort = 1'b0, rx_vld = 1'b0, rd_req = 1'b0;
    logic [7:0]  rx_dat = 8'h00;
    logic        tx_rdy;
    logic [7:0]  tx_dat;
    logic        pg_we = 1'b0, pg_stat = 1'b0;
    logic [10:0] pg_addr = '0;
    logic [7:0]  pg_dat = 8'hFF;

    int n_chk = 0, n_fail = 0;
    logic [7:0] dm [2048];
    logic [7:0] sm [2048];
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    pgread_seq u0 (
        .clk(clk), .rst_n(rst_n), .sel_grant(sel_grant), .abort(abort),
        .rx_vld(rx_vld), .rx_dat(rx_dat), .rd_req(rd_req), .tx_rdy(tx_rdy),
        .tx_dat(tx_dat), .pg_we(pg_we), .pg_stat(pg_stat), .pg_addr(pg_addr),
        .pg_dat(pg_dat)
    );

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic bit stat_exists(input int a);
        return (a < 8) || (a >= 32 && a < 40) || (a >= 64 && a < 72) || (a >= 256 && a < 320);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic prog(input bit stat, input int a, input logic [7:0] d);
        @(negedge clk);
        pg_we = 1'b1; pg_stat = stat; pg_addr = 11'(a); pg_dat = d;
        @(negedge clk);
        pg_we = 1'b0;
        if (!stat) dm[a] = dm[a] & d;
        else if (stat_exists(a)) sm[a] = sm[a] & d;
    endtask

    task automatic rx(input logic [7:0] b);
        rx_vld = 1'b1; rx_dat = b;
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic header(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        sel_grant = 1'b1;
        @(negedge clk);
        sel_grant = 1'b0;
        rx(cmd); rx(lo); rx(hi);
    endtask

    // driver side: model the stream and queue the first n bytes
    task automatic expect_stream(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi, input int n);
        logic [7:0] lst [$];
        logic [15:0] c;
        int a;
        a = {hi & 8'h07, lo};
        c = bcrc(bcrc(bcrc(16'h0, cmd), lo), hi & 8'h07);
        if (cmd == 8'hF0) begin
            while (a < 2048) begin lst.push_back(dm[a]); c = bcrc(c, dm[a]); a++; end
            lst.push_back(~c[7:0]); lst.push_back(~c[15:8]);
        end else if (cmd == 8'hAA) begin
            while (a < 2048) begin
                do begin lst.push_back(sm[a]); c = bcrc(c, sm[a]); a++; end while (a % 8 != 0);
                lst.push_back(~c[7:0]); lst.push_back(~c[15:8]); c = 16'h0;
            end
        end else if (cmd == 8'hA5) begin
            while (a < 2048) begin
                logic [7:0] r = sm[256 + a / 32];
                lst.push_back(r); c = bcrc(c, r);
                lst.push_back(~c[7:0]); lst.push_back(~c[15:8]); c = 16'h0;
                do begin lst.push_back(dm[a]); c = bcrc(c, dm[a]); a++; end while (a % 32 != 0);
                lst.push_back(~c[7:0]); lst.push_back(~c[15:8]); c = 16'h0;
            end
        end
        for (int i = 0; i < n; i++) exp_q.push_back(i < lst.size() ? lst[i] : 8'hFF);
    endtask

    // monitor side: take n bytes and compare against the queue
    task automatic pull(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hFF;
            check(tx_rdy === 1'b1 && tx_dat === e, $sformatf("%s byte %0d", tag, i),
                  {7'h0, tx_rdy, tx_dat}, {8'h01, e});
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
    endtask

    task automatic do_abort(input string tag);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(tx_rdy === 1'b0 && tx_dat === 8'hFF, tag, {7'h0, tx_rdy, tx_dat}, 16'h00FF);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin dm[i] = 8'hFF; sm[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tx_rdy === 1'b0 && tx_dat === 8'hFF, "R1 reset idle", {7'h0, tx_rdy, tx_dat}, 16'h00FF);
        // R1: stray header byte without select is ignored
        rx(8'hAA);
        check(tx_rdy === 1'b0, "R1 no select", {15'h0, tx_rdy}, 16'h0);

        for (int i = 0; i < 16; i++) prog(0, 16'h7F0 + i, 8'((i * 37) ^ 8'h5A));
        prog(0, 16'h7F2, 8'hF0);          // R12 AND-merge twice
        prog(0, 16'h7F2, 8'h3C);
        for (int i = 16'h7C3; i < 16'h7E0; i += 3) prog(0, i, 8'(i));
        prog(0, 16'h7E5, 8'h81);
        prog(1, 5, 8'hA5);
        prog(1, 6, 8'h0F);
        prog(1, 16'h010, 8'h00);          // R9 hole, ignored
        prog(1, 16'h7FE, 8'h00);          // R9 hole, ignored
        prog(1, 16'h023, 8'h77);
        prog(1, 16'h044, 8'h12);
        prog(1, 16'h13E, 8'hF6);
        prog(1, 16'h13F, 8'hFE);
        prog(1, 16'h13F, 8'h7F);          // R12

        // R2 R3 R4 R12: plain read, high byte FFh masked to 07h
        header(8'hF0, 8'hF0, 8'hFF);
        expect_stream(8'hF0, 8'hF0, 8'hFF, 22);
        pull(22, "R3 plain read / R2 mask / R12 / R4 ones");
        do_abort("R10 abort after plain read");

        // R10: plain read cut short, then re-run
        header(8'hF0, 8'h00, 8'h00);
        expect_stream(8'hF0, 8'h00, 8'h00, 5);
        pull(5, "R10 partial read");
        do_abort("R10 abort mid read");
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        check(tx_rdy === 1'b0, "R10 stays idle", {15'h0, tx_rdy}, 16'h0);

        // R5 R6 R9: status read across pages
        header(8'hAA, 8'h05, 8'h00);
        expect_stream(8'hAA, 8'h05, 8'h00, 25);
        pull(25, "R5 R6 R9 status pages");
        do_abort("R10 abort status");

        header(8'hAA, 8'h20, 8'h00);
        expect_stream(8'hAA, 8'h20, 8'h00, 40);
        pull(40, "R9 R6 status windows");
        do_abort("R10 abort status 2");

        // R6 R4: last status page then ones
        header(8'hAA, 8'hFE, 8'h07);
        expect_stream(8'hAA, 8'hFE, 8'h07, 7);
        pull(7, "R6 R4 status end");
        do_abort("R10 abort status 3");

        // R7 R8 R4: extended read over the last two pages
        header(8'hA5, 8'hC3, 8'h07);
        expect_stream(8'hA5, 8'hC3, 8'h07, 75);
        pull(75, "R7 R8 R4 extended read");
        do_abort("R10 abort ext");

        // R8: extended read from an untouched page
        header(8'hA5, 8'h40, 8'h00);
        expect_stream(8'hA5, 8'h40, 8'h00, 72);
        pull(72, "R8 extended page chain");
        do_abort("R10 abort ext 2");

        // R11: unknown command
        @(negedge clk); sel_grant = 1'b1; @(negedge clk); sel_grant = 1'b0;
        rx(8'h55);
        for (int i = 0; i < 3; i++) exp_q.push_back(8'hFF);
        pull(3, "R11 unknown command");
        do_abort("R10 abort unknown");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule